// File: doc/BRIEF.md
# Bi-Endian Word Load/Store Unit

This block sits between the load/store stage of a processor and a byte-addressed memory that it holds internally. It handles only whole 32-bit words. A request carries a base address, a signed byte displacement, a write flag, write data and a byte-order select. The unit adds the displacement to the base to form the effective byte address. It then checks that this address falls on a 4-byte boundary.

On an aligned store, the register value is split into four bytes. The bytes go to four consecutive byte locations in the order the select asks for. On an aligned load, the four bytes are read back and assembled into a register value using the same rule. The byte order is sampled with each request. This lets software write a word in one order and read it in the other, which yields the byte-reversed value.

A request whose effective address is not a multiple of 4 does not touch memory. It raises a fault pulse instead. Every response, including a faulted one, appears one clock after its request.

Top module: `bi_endian_lsu`

## Requirements
- R1: A synchronous active-high reset drives `rsp_done`, `align_fault` and `rsp_rdata` to zero. Reset does not erase stored bytes, so a word written before reset loads back unchanged after it.
- R2: The effective byte address is `req_base` plus the sign-extended `req_ofs`, taken modulo 2^ADDR_W. A negative displacement therefore reaches words below the base. An element index scaled by 4 (element 8 at displacement 32) reaches the matching word.
- R3: A request is aligned exactly when bits 1:0 of its effective address are 00. For a misaligned request, `align_fault` is 1 in the response cycle alongside `rsp_done`, and `rsp_rdata` is zero. `align_fault` is 0 in every other cycle.
- R4: A misaligned store changes no byte of memory.
- R5: With `req_order` = 0 (little-endian), a store at address A puts data bits 7:0 at A, 15:8 at A+1, 23:16 at A+2 and 31:24 at A+3. For example, 0x023BC581 stored at 100 writes 81, C5, 3B, 02 to addresses 100 to 103.
- R6: With `req_order` = 1 (big-endian), a store at address A puts bits 31:24 at A, 23:16 at A+1, 15:8 at A+2 and 7:0 at A+3. For example, 0x023BC581 stored at 100 writes 02, 3B, C5, 81 to addresses 100 to 103.
- R7: A little-endian load at A returns the byte at A in bits 7:0 and the byte at A+3 in bits 31:24. For example, bytes 81, C5, 3B, 02 at 200 to 203 load as 0x023BC581.
- R8: A big-endian load at A returns the byte at A in bits 31:24 and the byte at A+3 in bits 7:0. For example, the same bytes load as 0x81C53B02.
- R9: Each cycle with `req_valid` high produces `rsp_done` high on the next clock edge, for exactly one cycle. Without a request, `rsp_done` stays low. `rsp_rdata` carries the loaded word only in the response cycle of an aligned load, and is zero otherwise, including after stores.
- R10: The byte order is taken from each request on its own. A word stored in one order and loaded in the other comes back byte-reversed. A load issued in the cycle right after a store to the same word returns the newly stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_order | input | 1 | 0 = little-endian, 1 = big-endian |
| req_base | input | ADDR_W | Base byte address |
| req_ofs | input | OFS_W | Signed byte displacement |
| req_wdata | input | 32 | Store data |
| rsp_done | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Loaded word (zero unless an aligned load completes) |
| align_fault | output | 1 | Misaligned-request pulse in the response cycle |

## Verification
A store and an alignment fault can occur together in one request, when a write targets an address that is not a multiple of 4. The bench issues such stores at each of the three misaligned byte positions of many words. It expects a fault with zero read data, and then reads back the two words the bytes would have spilled into, in both orders, to confirm they still match the model. The bench also places a load in the cycle right after a store to the same word. This checks that the store commits before the following request reads the word.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic {
    ORDER_LITTLE = 1'b0,
    ORDER_BIG    = 1'b1
  } byte_order_e;

  typedef logic [LANES-1:0][LANE_W-1:0] lane_vec_t;
endpackage

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit #(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-3:0] word_idx,
  output logic              misaligned
);
  logic [ADDR_W-1:0] ofs_ext;

  // Pick the extension that matches the relative widths of offset and address.
  generate
    if (OFS_W >= ADDR_W) begin : g_trunc
      assign ofs_ext = ofs[ADDR_W-1:0];
    end else begin : g_sext
      assign ofs_ext = {{(ADDR_W-OFS_W){ofs[OFS_W-1]}}, ofs};
    end
  endgenerate

  assign eff_addr   = base + ofs_ext;
  assign word_idx   = eff_addr[ADDR_W-1:2];
  assign misaligned = (eff_addr[1:0] != 2'b00);
endmodule

// File: rtl/lsu_lane_scatter.sv
module lsu_lane_scatter
  import lsu_pkg::*;
(
  input  byte_order_e          order,
  input  logic [WORD_W-1:0]    word,
  output lane_vec_t            lanes
);
  // Lane k holds the byte at word address + k.
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lanes[k] = (order == ORDER_BIG) ? word[LANE_W*(LANES-1-k) +: LANE_W]
                                             : word[LANE_W*k +: LANE_W];
    end
  endgenerate
endmodule

// File: rtl/lsu_lane_gather.sv
module lsu_lane_gather
  import lsu_pkg::*;
(
  input  byte_order_e          order,
  input  lane_vec_t            lanes,
  output logic [WORD_W-1:0]    word
);
  generate
    for (genvar j = 0; j < LANES; j++) begin : g_byte
      assign word[LANE_W*j +: LANE_W] = (order == ORDER_BIG) ? lanes[LANES-1-j]
                                                             : lanes[j];
    end
  endgenerate
endmodule

// File: rtl/lsu_byte_bank.sv
module lsu_byte_bank #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store_q [DEPTH];

  // Single-port, read-first, registered output: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store_q[idx] <= wdata;
      rdata <= store_q[idx];
    end
  end
endmodule

// File: rtl/bi_endian_lsu.sv
module bi_endian_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_order,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic              align_fault
);
  localparam int WORDS = 1 << (ADDR_W - 2);

  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-3:0] word_idx;
  logic              misaligned;
  lane_vec_t         wr_lanes;
  lane_vec_t         rd_lanes;
  logic [WORD_W-1:0] rd_word;
  logic              mem_en;
  logic              mem_we;
  logic              done_q;
  logic              fault_q;
  logic              load_q;
  byte_order_e       order_q;

  lsu_addr_unit #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
    .base       (req_base),
    .ofs        (req_ofs),
    .eff_addr   (eff_addr),
    .word_idx   (word_idx),
    .misaligned (misaligned)
  );

  lsu_lane_scatter u_scatter (
    .order (byte_order_e'(req_order)),
    .word  (req_wdata),
    .lanes (wr_lanes)
  );

  assign mem_en = req_valid && !misaligned;
  assign mem_we = mem_en && req_write;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_bank
      lsu_byte_bank #(.DEPTH(WORDS), .WIDTH(LANE_W)) u_bank (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .idx   (word_idx),
        .wdata (wr_lanes[k]),
        .rdata (rd_lanes[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      load_q  <= 1'b0;
      order_q <= ORDER_LITTLE;
    end else begin
      done_q  <= req_valid;
      fault_q <= req_valid && misaligned;
      load_q  <= req_valid && !req_write && !misaligned;
      if (req_valid) order_q <= byte_order_e'(req_order);
    end
  end

  lsu_lane_gather u_gather (
    .order (order_q),
    .lanes (rd_lanes),
    .word  (rd_word)
  );

  assign rsp_done    = done_q;
  assign align_fault = fault_q;
  assign rsp_rdata   = load_q ? rd_word : '0;

  // R9
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_done);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_done);

  // R3
  fault_on_misalign_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && eff_addr[1:0] != 2'b00) |=> align_fault);

  // R3
  aligned_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && eff_addr[1:0] == 2'b00) |=> !align_fault);

  // R3
  fault_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (rsp_done && rsp_rdata == '0));

  // R9
  store_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == '0));
endmodule

// File: tb/tb_bi_endian_lsu.sv
`timescale 1ns/1ps
module tb_bi_endian_lsu;
  localparam int AW = 10;
  localparam int OW = 8;
  localparam int NB = 1 << AW;
  localparam int NW = NB / 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_write, req_order;
  logic [AW-1:0] req_base;
  logic [OW-1:0] req_ofs;
  logic [31:0]   req_wdata;
  logic          rsp_done, align_fault;
  logic [31:0]   rsp_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem_m [NB];

  always #10 clk = ~clk;

  bi_endian_lsu #(.ADDR_W(AW), .OFS_W(OW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_order(req_order), .req_base(req_base), .req_ofs(req_ofs),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .align_fault(align_fault)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_load(int a, bit big);
    logic [31:0] v;
    for (int k = 0; k < 4; k++)
      if (big) v[8*(3-k) +: 8] = mem_m[a+k];
      else     v[8*k +: 8]     = mem_m[a+k];
    return v;
  endfunction

  task automatic model_store(int a, bit big, logic [31:0] d);
    for (int k = 0; k < 4; k++)
      mem_m[a+k] = big ? d[8*(3-k) +: 8] : d[8*k +: 8];
  endtask

  function automatic int ea_of(logic [AW-1:0] b, logic [OW-1:0] o);
    return (int'(b) + int'($signed(o))) & (NB - 1);
  endfunction

  task automatic issue(bit wr, bit big, logic [AW-1:0] b, logic [OW-1:0] o,
                       logic [31:0] wd, output logic [31:0] rd,
                       output logic flt, output logic dn);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_order = big;
    req_base = b; req_ofs = o; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; flt = align_fault; dn = rsp_done;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic flt, dn;
    req_valid = 0; req_write = 0; req_order = 0;
    req_base = '0; req_ofs = '0; req_wdata = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done in reset", 32'(rsp_done), 0);
    check("R1 fault in reset", 32'(align_fault), 0);
    check("R1 rdata in reset", rsp_rdata, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 idle no done", 32'(rsp_done), 0);

    // Worked examples: little-endian store at 100, loads in both orders
    issue(1, 0, 10'd100, 8'd0, 32'h023BC581, rd, flt, dn);
    model_store(100, 0, 32'h023BC581);
    check("R9 store done", 32'(dn), 1);
    check("R9 store rdata zero", rd, 0);
    issue(0, 0, 10'd100, 8'd0, 0, rd, flt, dn);
    check("R7 R5 LE roundtrip", rd, 32'h023BC581);
    issue(0, 1, 10'd100, 8'd0, 0, rd, flt, dn);
    check("R10 R8 cross order", rd, 32'h81C53B02);
    // Big-endian store of 0x023BC581 at 100 must lay 02 3B C5 81
    issue(1, 1, 10'd100, 8'd0, 32'h023BC581, rd, flt, dn);
    issue(0, 0, 10'd100, 8'd0, 0, rd, flt, dn);
    check("R6 BE byte layout", rd, 32'h81C53B02);
    model_store(100, 1, 32'h023BC581);
    // Bytes 81 C5 3B 02 at 200..203
    issue(1, 1, 10'd200, 8'd0, 32'h81C53B02, rd, flt, dn);
    model_store(200, 1, 32'h81C53B02);
    issue(0, 0, 10'd200, 8'd0, 0, rd, flt, dn);
    check("R7 load LE at 200", rd, 32'h023BC581);
    issue(0, 1, 10'd200, 8'd0, 0, rd, flt, dn);
    check("R8 load BE at 200", rd, 32'h81C53B02);
    check("R3 aligned no fault", 32'(flt), 0);

    // Element 8 of an array at base 256 sits at displacement 32
    issue(1, 0, 10'd256, 8'd32, 32'hA5A5_0808, rd, flt, dn);
    model_store(288, 0, 32'hA5A5_0808);
    issue(0, 0, 10'd288, 8'd0, 0, rd, flt, dn);
    check("R2 scaled index", rd, 32'hA5A5_0808);

    // Sweep every word, alternating order on store
    for (int w = 0; w < NW; w++) begin
      logic [31:0] v = 32'h9E3779B9 * w + 32'h1357_2468;
      issue(1, w[0], AW'(4*w), 8'd0, v, rd, flt, dn);
      model_store(4*w, w[0], v);
    end
    for (int w = 0; w < NW; w++) begin
      issue(0, 0, AW'(4*w), 8'd0, 0, rd, flt, dn);
      check("R7 R5 R6 sweep LE", rd, model_load(4*w, 0));
      issue(0, 1, AW'(4*w), 8'd0, 0, rd, flt, dn);
      check("R8 R5 R6 sweep BE", rd, model_load(4*w, 1));
    end

    // Negative and positive displacements with wraparound
    for (int i = 0; i < 32; i++) begin
      logic [AW-1:0] b = AW'(4 * ((i * 37) % NW));
      logic [OW-1:0] o = OW'((i % 2 == 1) ? -4 * i : 4 * i);
      int ea = ea_of(b, o);
      issue(0, i[1], b, o, 0, rd, flt, dn);
      check("R2 displacement load", rd, model_load(ea, i[1]));
      check("R2 displacement aligned", 32'(flt), 0);
    end

    // Misaligned loads and stores: fault, zero data, memory untouched
    for (int w = 0; w < 24; w++) begin
      for (int lo = 1; lo < 4; lo++) begin
        logic [AW-1:0] b = AW'(4 * ((w * 11) % (NW - 1)));
        int ea = ea_of(b, OW'(lo));
        int wa = ea & ~3;
        issue(1, lo[0], b, OW'(lo), 32'hDEADBEEF, rd, flt, dn);
        check("R3 misaligned store fault", 32'(flt), 1);
        check("R3 misaligned store done", 32'(dn), 1);
        issue(0, 0, AW'(wa), 8'd0, 0, rd, flt, dn);
        check("R4 word unchanged", rd, model_load(wa, 0));
        check("R3 fault one cycle", 32'(flt), 0);
        issue(0, 1, AW'(wa + 4), 8'd0, 0, rd, flt, dn);
        check("R4 next word unchanged", rd, model_load(wa + 4, 1));
        issue(0, lo[1], b, OW'(lo), 0, rd, flt, dn);
        check("R3 misaligned load fault", 32'(flt), 1);
        check("R3 misaligned load zero", rd, 0);
      end
    end

    // Back-to-back: store then load of the same word in the next cycle
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v = 32'hC0DE_0000 + 32'(i * 4097);
      int a = 4 * (i * 29 + 3);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_order = i[0];
      req_base = AW'(a); req_ofs = '0; req_wdata = v;
      @(negedge clk);
      check("R9 b2b store done", 32'(rsp_done), 1);
      req_write = 0; req_order = ~i[0];
      model_store(a, i[0], v);
      @(negedge clk);
      req_valid = 0;
      check("R10 b2b load", rsp_rdata, model_load(a, ~i[0]));
      @(negedge clk);
      check("R9 done single cycle", 32'(rsp_done), 0);
      check("R9 idle rdata zero", rsp_rdata, 0);
    end

    // Reset keeps memory
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 outputs clear", {rsp_rdata[30:0], rsp_done}, 0);
    rst = 1'b0;
    issue(0, 0, 10'd100, 8'd0, 0, rd, flt, dn);
    check("R1 memory retained", rd, model_load(100, 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule